// File: doc/BRIEF.md
# Wide Bus Receive Residue Holder

This block sits between a two-byte-wide receive data path and a byte-wide DMA sink. Words arrive from the bus with a valid/ready strobe pair. Each word is split into bytes, low lane first, and the bytes leave through a registered byte output with its own valid/ready pair. A word marked as the odd tail of a block move is treated differently. Its low byte is forwarded as usual. Its high byte is parked in a one-byte residue register and is not forwarded, and a residue status flag is raised. This applies to the last word of any block move, chained or not.

The flag decides how the next receive begins. When a receive-start strobe arrives while the flag is set, the parked byte is sent as the first output byte, ahead of any new bus data. The flag drops in the same cycle that byte is loaded into the output register. Software sees the flag on a one-bit status output. Writing a one through the control write port clears it, and no write of zero is needed before it can be set again. A bus send operation also clears the flag, and so does any 8-bit (narrow) beat. When the flag is cleared by any of these, the parked byte is discarded.

Top module: `wide_rx_residue`

## Requirements
- R1: After synchronous reset, `out_valid` is 0, `csr_flag` is 0 and `in_ready` is 1.
- R2: A wide word (`in_wide`=1, `in_tail_odd`=0) produces two output bytes: `in_data[7:0]` first, then `in_data[15:8]`.
- R3: A wide word with `in_tail_odd`=1 produces only its low byte. Its high byte is stored as the residue and never appears on the output by itself. `csr_flag` reads 1 from the cycle after acceptance.
- R4: A control write (`csr_wr`=1) with `csr_wdata`=1 clears `csr_flag` on the next cycle. A write with `csr_wdata`=0 leaves it unchanged. A later capture sets the flag again without any intervening write.
- R5: A `rx_start` pulse while `csr_flag`=1 makes the residue byte the next output byte. `in_ready` stays low until that byte has been loaded. `csr_flag` falls on the same edge at which that byte appears on `out_data` with `out_valid`=1.
- R6: A `rx_start` pulse while `csr_flag`=0 emits nothing extra, and the next output byte comes straight from the bus.
- R7: A `send_op` pulse clears `csr_flag`, and a following `rx_start` emits no residue byte.
- R8: A narrow beat (`in_wide`=0) produces only `in_data[7:0]` and clears `csr_flag`.
- R9: If a clear (control write of one or `send_op`) coincides with a residue capture, the flag ends up 0.
- R10: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Bus word valid |
| in_ready | output | 1 | Bus word accepted when high with `in_valid` |
| in_data | input | 2*BYTE_W | Bus word, low lane in the low bits |
| in_wide | input | 1 | 1: two-byte beat, 0: narrow beat (low byte only) |
| in_tail_odd | input | 1 | Wide beat ends a block move on an odd byte count |
| rx_start | input | 1 | Pulse: a new data receive transfer begins |
| send_op | input | 1 | Pulse: a bus send operation occurred |
| csr_wr | input | 1 | Control write strobe for the residue bit |
| csr_wdata | input | 1 | Written value, 1 clears the flag |
| csr_flag | output | 1 | Residue flag read value |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink ready for an output byte |
| out_data | output | BYTE_W | Output byte |

## Verification
The assertions assume that the inputs are defined from the first clock edge and that a bus word is held stable until it is accepted. They also assume that `in_tail_odd` has a meaning only on wide beats. The bench drives every input just after the falling edge and keeps each word up until the edge where `in_ready` was seen high. The reference model treats a residue as committed to the output when `rx_start` is pulsed. The stimulus therefore waits for `csr_flag` to fall before it issues the next clear, send or start. Random traffic mixes full words, odd tails, narrow beats, starts, sends and control writes with random sink stalls. Directed cases pin down the cycle of the residue hand-off and the case where a clear and a capture fall in the same cycle.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
  // Source selected for the next output byte
  typedef enum logic [1:0] {
    SRC_NONE    = 2'd0,
    SRC_HIGH    = 2'd1,
    SRC_RESIDUE = 2'd2,
    SRC_BUS     = 2'd3
  } out_src_e;
endpackage

// File: rtl/wrr_beat_decode.sv
module wrr_beat_decode #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              in_fire,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_wide,
  input  logic              in_tail_odd,
  input  logic              csr_wr,
  input  logic              csr_wdata,
  input  logic              send_op,
  output logic [BYTE_W-1:0] lo_byte,
  output logic [BYTE_W-1:0] hi_byte,
  output logic              split_hi,
  output logic              capture,
  output logic              clear_req
);
  logic narrow_fire;

  assign lo_byte     = in_data[BYTE_W-1:0];
  assign hi_byte     = in_data[WORD_W-1:BYTE_W];
  // high lane is forwarded only for a complete wide word
  assign split_hi    = in_wide && !in_tail_odd;
  assign capture     = in_fire && in_wide && in_tail_odd;
  assign narrow_fire = in_fire && !in_wide;
  assign clear_req   = (csr_wr && csr_wdata) || send_op || narrow_fire;
endmodule

// File: rtl/wrr_flag_ctl.sv
module wrr_flag_ctl #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [BYTE_W-1:0] cap_byte,
  input  logic              clear_req,
  input  logic              rx_start,
  input  logic              consume,
  output logic              flag,
  output logic              drain,
  output logic [BYTE_W-1:0] residue
);
  logic flag_n;
  logic drain_n;

  // clear has priority over capture, capture over consumption
  always_comb begin
    if (clear_req)    flag_n = 1'b0;
    else if (capture) flag_n = 1'b1;
    else if (consume) flag_n = 1'b0;
    else              flag_n = flag;
  end

  // a start only arms the drain if a byte is already parked
  assign drain_n = (drain || (rx_start && flag)) && flag_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag    <= 1'b0;
      drain   <= 1'b0;
      residue <= '0;
    end else begin
      flag  <= flag_n;
      drain <= drain_n;
      if (capture) residue <= cap_byte;
    end
  end
endmodule

// File: rtl/wrr_byte_out.sv
module wrr_byte_out
  import wrr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] lo_byte,
  input  logic [BYTE_W-1:0] hi_byte,
  input  logic              split_hi,
  input  logic              drain,
  input  logic [BYTE_W-1:0] residue,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              in_fire,
  output logic              consume,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data
);
  logic              hi_vld;
  logic [BYTE_W-1:0] hi_q;
  logic              advance;
  out_src_e          src;

  assign advance = !out_valid || out_ready;

  // pending high lane first, then a parked residue, then new bus data
  always_comb begin
    src = SRC_NONE;
    if (hi_vld)        src = SRC_HIGH;
    else if (drain)    src = SRC_RESIDUE;
    else if (in_valid) src = SRC_BUS;
  end

  assign in_ready = advance && !hi_vld && !drain;
  assign in_fire  = in_valid && in_ready;
  assign consume  = advance && (src == SRC_RESIDUE);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      hi_vld    <= 1'b0;
      hi_q      <= '0;
    end else if (advance) begin
      unique case (src)
        SRC_HIGH: begin
          out_data  <= hi_q;
          out_valid <= 1'b1;
          hi_vld    <= 1'b0;
        end
        SRC_RESIDUE: begin
          out_data  <= residue;
          out_valid <= 1'b1;
        end
        SRC_BUS: begin
          out_data  <= lo_byte;
          out_valid <= 1'b1;
          if (split_hi) begin
            hi_q   <= hi_byte;
            hi_vld <= 1'b1;
          end
        end
        default: out_valid <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/wide_rx_residue.sv
module wide_rx_residue #(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [2*BYTE_W-1:0]   in_data,
  input  logic                  in_wide,
  input  logic                  in_tail_odd,
  input  logic                  rx_start,
  input  logic                  send_op,
  input  logic                  csr_wr,
  input  logic                  csr_wdata,
  output logic                  csr_flag,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [BYTE_W-1:0]     out_data
);
  logic              in_fire;
  logic [BYTE_W-1:0] lo_byte;
  logic [BYTE_W-1:0] hi_byte;
  logic              split_hi;
  logic              capture;
  logic              clear_req;
  logic              consume;
  logic              drain;
  logic [BYTE_W-1:0] residue;

  wrr_beat_decode #(.BYTE_W(BYTE_W)) u_decode (
    .in_fire     (in_fire),
    .in_data     (in_data),
    .in_wide     (in_wide),
    .in_tail_odd (in_tail_odd),
    .csr_wr      (csr_wr),
    .csr_wdata   (csr_wdata),
    .send_op     (send_op),
    .lo_byte     (lo_byte),
    .hi_byte     (hi_byte),
    .split_hi    (split_hi),
    .capture     (capture),
    .clear_req   (clear_req)
  );

  wrr_flag_ctl #(.BYTE_W(BYTE_W)) u_flag (
    .clk       (clk),
    .rst       (rst),
    .capture   (capture),
    .cap_byte  (hi_byte),
    .clear_req (clear_req),
    .rx_start  (rx_start),
    .consume   (consume),
    .flag      (csr_flag),
    .drain     (drain),
    .residue   (residue)
  );

  wrr_byte_out #(.BYTE_W(BYTE_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .lo_byte   (lo_byte),
    .hi_byte   (hi_byte),
    .split_hi  (split_hi),
    .drain     (drain),
    .residue   (residue),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .in_fire   (in_fire),
    .consume   (consume),
    .out_valid (out_valid),
    .out_data  (out_data)
  );
endmodule

// File: rtl/wrr_checker.sv
module wrr_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_wide,
  input logic              in_tail_odd,
  input logic              rx_start,
  input logic              send_op,
  input logic              csr_wr,
  input logic              csr_wdata,
  input logic              csr_flag,
  input logic              out_valid,
  input logic              out_ready,
  input logic [BYTE_W-1:0] out_data
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !csr_flag && in_ready));

  assert_capture_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_wide && in_tail_odd && !(csr_wr && csr_wdata) && !send_op)
    |=> csr_flag);

  assert_write_one_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && csr_wdata) |=> !csr_flag);

  assert_flag_fall_with_byte_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(csr_flag) && !$past(csr_wr && csr_wdata) && !$past(send_op)
     && !$past(in_valid && in_ready && !in_wide)) |-> out_valid);

  assert_no_residue_when_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_start && !csr_flag && !out_valid && !in_valid) |=> (in_ready && !out_valid));

  assert_send_clears_R7: assert property (@(posedge clk) disable iff (rst)
    send_op |=> !csr_flag);

  assert_narrow_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_wide) |=> !csr_flag);

  assert_clear_beats_capture_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_wide && in_tail_odd && (send_op || (csr_wr && csr_wdata)))
    |=> !csr_flag);

  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind wide_rx_residue wrr_checker #(.BYTE_W(BYTE_W)) u_wrr_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_wide     (in_wide),
  .in_tail_odd (in_tail_odd),
  .rx_start    (rx_start),
  .send_op     (send_op),
  .csr_wr      (csr_wr),
  .csr_wdata   (csr_wdata),
  .csr_flag    (csr_flag),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data)
);

// File: tb/wide_rx_residue_tb.sv
module wide_rx_residue_tb;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  logic              clk = 1'b0;
  logic              rst;
  logic              in_valid;
  logic              in_ready;
  logic [WORD_W-1:0] in_data;
  logic              in_wide;
  logic              in_tail_odd;
  logic              rx_start;
  logic              send_op;
  logic              csr_wr;
  logic              csr_wdata;
  logic              csr_flag;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [BYTE_W-1:0] out_data;

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    stall  = 1'b0;
  bit    fast   = 1'b0;
  bit    done   = 1'b0;
  string cur_req = "R2";

  logic [BYTE_W-1:0] expq[$];
  logic              model_flag = 1'b0;
  logic [BYTE_W-1:0] model_res  = '0;

  always #2 clk = ~clk;

  wide_rx_residue #(.BYTE_W(BYTE_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_wide(in_wide), .in_tail_odd(in_tail_odd),
    .rx_start(rx_start), .send_op(send_op), .csr_wr(csr_wr),
    .csr_wdata(csr_wdata), .csr_flag(csr_flag), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // sink: choose ready, then record the byte the next edge will take
  always @(negedge clk) begin
    logic [BYTE_W-1:0] e;
    out_ready = stall ? 1'b0 : (fast ? 1'b1 : (($urandom % 4) != 0));
    if (!rst && out_valid && out_ready) begin
      if (expq.size() == 0) begin
        check(1'b0, cur_req, "unexpected output byte", out_data, 0);
      end else begin
        e = expq.pop_front();
        check(out_data == e, cur_req, "output byte", out_data, e);
      end
    end
  end

  task automatic put_word(input logic [WORD_W-1:0] d, input bit wide,
                          input bit odd, input bit clr);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_wide = wide; in_tail_odd = odd;
    csr_wr = clr; csr_wdata = clr;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0; csr_wr = 1'b0; csr_wdata = 1'b0;
    expq.push_back(d[BYTE_W-1:0]);
    if (!wide) model_flag = 1'b0;
    else if (!odd) expq.push_back(d[WORD_W-1:BYTE_W]);
    else begin
      model_res  = d[WORD_W-1:BYTE_W];
      model_flag = 1'b1;
    end
    if (clr) model_flag = 1'b0;
  endtask

  task automatic do_rx_start;
    bit had;
    had = model_flag;
    @(negedge clk);
    rx_start = 1'b1;
    @(posedge clk);
    #1;
    rx_start = 1'b0;
    if (had) begin
      expq.push_back(model_res);
      model_flag = 1'b0;
      for (int i = 0; i < 300; i++) begin
        if (!csr_flag) break;
        @(negedge clk);
        #1;
      end
      check(!csr_flag, "R5", "flag after residue hand-off", csr_flag, 0);
    end
  endtask

  task automatic do_send;
    @(negedge clk);
    send_op = 1'b1;
    @(posedge clk);
    #1;
    send_op = 1'b0;
    model_flag = 1'b0;
  endtask

  task automatic do_csr(input bit wd);
    @(negedge clk);
    csr_wr = 1'b1; csr_wdata = wd;
    @(posedge clk);
    #1;
    csr_wr = 1'b0; csr_wdata = 1'b0;
    if (wd) model_flag = 1'b0;
  endtask

  task automatic wait_idle;
    fast = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      #1;
      if (expq.size() == 0 && !out_valid) break;
    end
    fast = 1'b0;
    check(expq.size() == 0 && !out_valid, cur_req, "bytes still missing", expq.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run hung actual=%0d expected=%0d", 1, 0);
      report();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    rst = 1'b1; in_valid = 1'b0; in_data = '0; in_wide = 1'b0; in_tail_odd = 1'b0;
    rx_start = 1'b0; send_op = 1'b0; csr_wr = 1'b0; csr_wdata = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(!out_valid, "R1", "out_valid after reset", out_valid, 0);
    check(!csr_flag,  "R1", "flag after reset", csr_flag, 0);
    check(in_ready,   "R1", "in_ready after reset", in_ready, 1);

    // R2 full words, low lane first
    cur_req = "R2";
    put_word(16'hB2A1, 1, 0, 0);
    put_word(16'hD4C3, 1, 0, 0);
    wait_idle();

    // R3 odd tail parks the high byte
    cur_req = "R3";
    put_word(16'h5A3C, 1, 1, 0);
    wait_idle();
    check(csr_flag, "R3", "flag after odd tail", csr_flag, 1);

    // R10 output held under backpressure
    cur_req = "R10";
    stall = 1'b1;
    put_word(16'h7766, 1, 0, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      #1;
      check(out_valid && out_data == 8'h66, "R10", "held byte", out_data, 8'h66);
    end
    stall = 1'b0;
    wait_idle();

    // R4 write of zero leaves the flag
    do_csr(1'b0);
    check(csr_flag, "R4", "flag after write of zero", csr_flag, 1);

    // R5 exact hand-off cycle
    cur_req = "R5";
    stall = 1'b1;
    @(negedge clk);
    rx_start = 1'b1;
    @(posedge clk);
    #1;
    rx_start = 1'b0;
    check(csr_flag,   "R5", "flag before hand-off", csr_flag, 1);
    check(!out_valid, "R5", "out_valid before hand-off", out_valid, 0);
    check(!in_ready,  "R5", "bus blocked while residue pending", in_ready, 0);
    @(posedge clk);
    #1;
    check(!csr_flag, "R5", "flag at hand-off", csr_flag, 0);
    check(out_valid && out_data == 8'h5A, "R5", "residue byte", out_data, 8'h5A);
    expq.push_back(8'h5A);
    model_flag = 1'b0;
    stall = 1'b0;
    wait_idle();

    // R6 start with nothing parked
    cur_req = "R6";
    do_rx_start();
    check(!out_valid && in_ready, "R6", "no extra byte on start", out_valid, 0);
    put_word(16'h2211, 1, 0, 0);
    wait_idle();

    // R4 clear by write of one, then set again
    cur_req = "R4";
    put_word(16'h9988, 1, 1, 0);
    do_csr(1'b1);
    check(!csr_flag, "R4", "flag after write of one", csr_flag, 0);
    put_word(16'hAA77, 1, 1, 0);
    check(csr_flag, "R4", "flag set again without write of zero", csr_flag, 1);

    // R7 send clears, start then emits nothing
    cur_req = "R7";
    do_send();
    check(!csr_flag, "R7", "flag after send", csr_flag, 0);
    do_rx_start();
    check(!out_valid, "R7", "no residue after send", out_valid, 0);
    wait_idle();

    // R8 narrow beat
    cur_req = "R8";
    put_word(16'hCCBB, 1, 1, 0);
    put_word(16'hEEDD, 0, 0, 0);
    wait_idle();
    check(!csr_flag, "R8", "flag after narrow beat", csr_flag, 0);

    // R9 clear and capture in one cycle
    cur_req = "R9";
    put_word(16'h4433, 1, 1, 1);
    wait_idle();
    check(!csr_flag, "R9", "clear wins over capture", csr_flag, 0);
    do_rx_start();
    check(!out_valid, "R9", "no residue after lost capture", out_valid, 0);
    wait_idle();

    // random mix over chained and single moves
    cur_req = "R2";
    for (int i = 0; i < 400; i++) begin
      int r;
      logic [WORD_W-1:0] d;
      r = $urandom % 100;
      d = WORD_W'($urandom);
      if (r < 45)      put_word(d, 1, 0, ($urandom % 20) == 0);
      else if (r < 62) put_word(d, 1, 1, ($urandom % 20) == 0);
      else if (r < 70) put_word(d, 0, 0, 0);
      else if (r < 82) do_rx_start();
      else if (r < 88) do_send();
      else if (r < 94) do_csr(1'b1);
      else             do_csr(1'b0);
    end
    wait_idle();
    check(csr_flag == model_flag, "R4", "flag at end of random run", csr_flag, model_flag);

    done = 1'b1;
    report();
    $finish;
  end
endmodule